// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block turns inbound posted memory writes into level interrupts for a host processor. Each write arriving on the message stream is compared with a programmed 64-bit target address and a 16-bit data pattern under a 16-bit compare mask. When both comparisons succeed, the five low data bits name one of 32 vectors, and that vector's pending bit is latched. A single interrupt output stays high while at least one pending vector is also unmasked.

Software drives the block through a small register port. It can read the pending bits and clear them by writing ones. It can mask or unmask vectors through separate set and clear registers, so no read-modify-write is needed. It also programs the target address and the data match word. Bit 0 of the low target-address register is the receive enable. The message stream is valid/ready. `msg_ready` is held high, so the block never applies back-pressure and takes one write per cycle whenever `msg_valid` is high. A write that does not match is consumed and dropped.

Top module: `msi_rx_top`

## Requirements
- R1: After reset all pending bits read 0, all 32 mask bits read 1, and `irq` is 0.
- R2: An accepted write that matches sets pending bit `msg_data[4:0]` at the next clock edge. Pending bits are read at offset 0x00.
- R3: The address matches when `msg_addr[63:2]` equals {target-high, target-low[31:2]}. Bits 1:0 are ignored. While target-low bit 0 (the enable) is 0, every write is ignored.
- R4: The data matches when (`msg_data[15:0]` & M) == (P & M), where M is data-config bits 31:16 and P is bits 15:0. `msg_data[31:16]` is ignored.
- R5: Writing a word to offset 0x08 clears each pending bit whose position holds a 1. The other pending bits are kept.
- R6: Writing ones to offset 0x10 masks the matching vectors, and writing ones to offset 0x14 unmasks them. Both offsets read back the mask, where 1 means masked. If one write both sets and clears the same bit, masking wins.
- R7: `irq` is 1 exactly when some pending bit has its mask bit at 0. It follows register changes with no further delay.
- R8: If a clear at 0x08 and a matching write for the same vector fall in the same cycle, the pending bit stays set.
- R9: `msg_ready` is always 1. A cycle with `msg_valid` low changes no pending bit.
- R10: Target-low (offset 0x20), target-high (0x24) and data-config (0x28) read back the value last written. Data-config resets to 0xFFE06540.
- R11: A pending bit stays set until it is cleared. A repeated write for the same vector leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound write present |
| msg_ready | output | 1 | Write accepted (always 1) |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Any fault in the match path or the pending latch shows up as a wrong pending word at offset 0x00, one clock edge after the write that caused it. A wrong mask or a wrong OR-reduction shows up on `irq` in that same cycle. The bench therefore reads the pending word and `irq` after every stimulus. This covers near-miss addresses, data words that differ only in masked or unmasked bits, and a clear that collides with a new message, so a faulty bit is caught within one transaction.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned NUM_VEC  = 32;
  localparam int unsigned VEC_W    = $clog2(NUM_VEC);
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned MSG_AW   = 64;
  localparam int unsigned TGT_W    = MSG_AW - 2;
  localparam int unsigned PAT_W    = 16;

  localparam logic [REG_AW-1:0] OFS_PEND   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_MSET   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MCLR   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_TGT_LO = 8'h20;
  localparam logic [REG_AW-1:0] OFS_TGT_HI = 8'h24;
  localparam logic [REG_AW-1:0] OFS_DCFG   = 8'h28;

  typedef struct packed {
    logic             en;
    logic [TGT_W-1:0] tgt;
    logic [PAT_W-1:0] cmask;
    logic [PAT_W-1:0] pat;
  } match_cfg_t;
endpackage

// File: rtl/msi_rx_cfg.sv
module msi_rx_cfg
  import msi_rx_pkg::*;
#(
  parameter logic [REG_DW-1:0] DCFG_RST = 32'hFFE0_6540
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output match_cfg_t        cfg,
  output logic [REG_DW-1:0] tgt_lo,
  output logic [REG_DW-1:0] tgt_hi,
  output logic [REG_DW-1:0] dcfg,
  output logic [NUM_VEC-1:0] clr_req,
  output logic [NUM_VEC-1:0] mset_req,
  output logic [NUM_VEC-1:0] mclr_req
);
  logic [REG_DW-1:0] lo_q, hi_q, dcfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      dcfg_q <= DCFG_RST;
    end else if (wr_en) begin
      if (wr_addr == OFS_TGT_LO) lo_q   <= wr_data;
      if (wr_addr == OFS_TGT_HI) hi_q   <= wr_data;
      if (wr_addr == OFS_DCFG)   dcfg_q <= wr_data;
    end
  end

  always_comb begin
    clr_req  = '0;
    mset_req = '0;
    mclr_req = '0;
    if (wr_en) begin
      if (wr_addr == OFS_CLEAR) clr_req  = wr_data[NUM_VEC-1:0];
      if (wr_addr == OFS_MSET)  mset_req = wr_data[NUM_VEC-1:0];
      if (wr_addr == OFS_MCLR)  mclr_req = wr_data[NUM_VEC-1:0];
    end
  end

  always_comb begin
    cfg.en    = lo_q[0];
    cfg.tgt   = {hi_q, lo_q[REG_DW-1:2]};
    cfg.cmask = dcfg_q[REG_DW-1:PAT_W];
    cfg.pat   = dcfg_q[PAT_W-1:0];
  end

  assign tgt_lo = lo_q;
  assign tgt_hi = hi_q;
  assign dcfg   = dcfg_q;

  // R10: a register write is visible on the next cycle
  a_r10_dcfg_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_DCFG) |=> (dcfg == $past(wr_data)));
endmodule

// File: rtl/msi_rx_match.sv
module msi_rx_match
  import msi_rx_pkg::*;
(
  input  match_cfg_t        cfg,
  input  logic              valid,
  input  logic [MSG_AW-1:0] addr,
  input  logic [REG_DW-1:0] data,
  output logic              hit,
  output logic [VEC_W-1:0]  vec
);
  logic addr_ok, data_ok;
  logic unused_upper;

  assign unused_upper = ^{data[REG_DW-1:PAT_W], addr[1:0]};
  assign addr_ok = (addr[MSG_AW-1:2] == cfg.tgt);
  assign data_ok = ((data[PAT_W-1:0] & cfg.cmask) == (cfg.pat & cfg.cmask));
  assign hit     = valid && cfg.en && addr_ok && data_ok;
  assign vec     = data[VEC_W-1:0];
endmodule

// File: rtl/msi_rx_bank.sv
module msi_rx_bank
  import msi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [VEC_W-1:0]   vec,
  input  logic [NUM_VEC-1:0] clr_req,
  input  logic [NUM_VEC-1:0] mset_req,
  input  logic [NUM_VEC-1:0] mclr_req,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] mask,
  output logic               irq
);
  logic [NUM_VEC-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (hit) set_vec[vec] = 1'b1;
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        mask[i] <= 1'b1;
      end else begin
        if (set_vec[i])      pend[i] <= 1'b1;
        else if (clr_req[i]) pend[i] <= 1'b0;
        if (mset_req[i])      mask[i] <= 1'b1;
        else if (mclr_req[i]) mask[i] <= 1'b0;
      end
    end
  end

  assign irq = |(pend & ~mask);

  // R2: a hit latches its vector
  a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend[$past(vec)]);
  // R8: a new message beats a clear on the same vector
  a_r8_msg_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_req) != '0) |=> ((pend & $past(set_vec & clr_req)) == $past(set_vec & clr_req)));
  // R5: cleared bits fall unless a message hits them
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req != '0) |=> ((pend & $past(clr_req & ~set_vec)) == '0));
  // R11: pending bits without a clear stay set
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr_req)) == $past(pend & ~clr_req)));
  // R6: masking wins over unmasking
  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_req != '0) |=> ((mask & $past(mset_req)) == $past(mset_req)));
endmodule

// File: rtl/msi_rx_top.sv
module msi_rx_top
  import msi_rx_pkg::*;
#(
  parameter logic [31:0] DCFG_RST = 32'hFFE0_6540
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_valid,
  output logic        msg_ready,
  input  logic [63:0] msg_addr,
  input  logic [31:0] msg_data,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  match_cfg_t         cfg;
  logic [REG_DW-1:0]  tgt_lo, tgt_hi, dcfg;
  logic [NUM_VEC-1:0] clr_req, mset_req, mclr_req, pend, mask;
  logic               hit;
  logic [VEC_W-1:0]   vec;

  assign msg_ready = 1'b1;

  msi_rx_cfg #(.DCFG_RST(DCFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .cfg(cfg), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi),
    .dcfg(dcfg), .clr_req(clr_req), .mset_req(mset_req), .mclr_req(mclr_req)
  );

  msi_rx_match u_match (
    .cfg(cfg), .valid(msg_valid && msg_ready), .addr(msg_addr),
    .data(msg_data), .hit(hit), .vec(vec)
  );

  msi_rx_bank u_bank (
    .clk(clk), .rst_n(rst_n), .hit(hit), .vec(vec), .clr_req(clr_req),
    .mset_req(mset_req), .mclr_req(mclr_req), .pend(pend), .mask(mask),
    .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_PEND:           reg_rdata = pend;
      OFS_MSET, OFS_MCLR: reg_rdata = mask;
      OFS_TGT_LO:         reg_rdata = tgt_lo;
      OFS_TGT_HI:         reg_rdata = tgt_hi;
      OFS_DCFG:           reg_rdata = dcfg;
      default:            reg_rdata = '0;
    endcase
  end

  // R3: with the enable bit low and no clear, pending bits do not move
  a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_lo[0] && clr_req == '0) |=> $stable(pend));
  // R9: no pending bit rises in a cycle without a valid message
  a_r9_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> ((pend & ~$past(pend)) == '0));
endmodule

// File: tb/tb_msi_rx_top.sv
module tb_msi_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
    logic        exp_irq;
  } item_t;
  item_t exp_q[$];
  event  chk_ev;

  always #5 clk = ~clk;

  msi_rx_top dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // monitor: pops expectations and compares read data and irq
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp || irq !== it.exp_irq) begin
          errors++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, reg_rdata, irq, it.exp, it.exp_irq);
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_msg(input logic [63:0] a, input logic [31:0] d, input logic v = 1'b1);
    @(negedge clk);
    msg_valid = v; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic clear_and_msg(input logic [31:0] c, input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = c;
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    reg_wr = 1'b0; msg_valid = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e,
                            input logic ei, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    #1;
    it.tag = tag; it.exp = e; it.exp_irq = ei;
    exp_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  localparam logic [63:0] BASE = 64'h0000_0001_0000_F000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_reg(8'h00, 32'h0, 1'b0, "R1 pending after reset");
    expect_reg(8'h10, 32'hFFFF_FFFF, 1'b0, "R1 mask after reset");
    expect_reg(8'h28, 32'hFFE0_6540, 1'b0, "R10 data-config reset");

    reg_write(8'h24, 32'h0000_0001);
    reg_write(8'h20, 32'h0000_F001);
    expect_reg(8'h20, 32'h0000_F001, 1'b0, "R10 target-low readback");
    expect_reg(8'h24, 32'h0000_0001, 1'b0, "R10 target-high readback");

    send_msg(BASE, 32'h0000_6545);
    expect_reg(8'h00, 32'h0000_0020, 1'b0, "R2 vector 5 latched, R7 masked");

    reg_write(8'h14, 32'h0000_0020);
    expect_reg(8'h14, 32'hFFFF_FFDF, 1'b1, "R6 unmask vector 5, R7 irq high");

    send_msg(BASE | 64'h2, 32'h0000_655F);
    expect_reg(8'h00, 32'h8000_0020, 1'b1, "R3 address bits 1:0 ignored");

    send_msg(64'h0000_0001_0000_E000, 32'h0000_6541);
    expect_reg(8'h00, 32'h8000_0020, 1'b1, "R3 low address mismatch ignored");
    send_msg(64'h0000_0002_0000_F000, 32'h0000_6541);
    expect_reg(8'h00, 32'h8000_0020, 1'b1, "R3 high address mismatch ignored");

    send_msg(BASE, 32'h0000_7541);
    expect_reg(8'h00, 32'h8000_0020, 1'b1, "R4 compared data bit differs");
    send_msg(BASE, 32'hABCD_6543);
    expect_reg(8'h00, 32'h8000_0028, 1'b1, "R4 upper data ignored");

    reg_write(8'h28, 32'hFF00_6500);
    expect_reg(8'h28, 32'hFF00_6500, 1'b1, "R10 data-config readback");
    send_msg(BASE, 32'h0000_6577);
    expect_reg(8'h00, 32'h8080_0028, 1'b1, "R4 new compare mask vector 23");

    reg_write(8'h08, 32'h0000_0020);
    expect_reg(8'h00, 32'h8080_0008, 1'b0, "R5 clear vector 5, R7 irq low");

    reg_write(8'h14, 32'h0000_0008);
    expect_reg(8'h00, 32'h8080_0008, 1'b1, "R7 unmask pending vector 3");

    clear_and_msg(32'h8000_0008, BASE, 32'h0000_6503);
    expect_reg(8'h00, 32'h0080_0008, 1'b1, "R8 message beats clear, R5 bit 31 cleared");

    send_msg(BASE, 32'h0000_6577);
    expect_reg(8'h00, 32'h0080_0008, 1'b1, "R11 repeated vector unchanged");

    send_msg(BASE, 32'h0000_6500, 1'b0);
    expect_reg(8'h00, 32'h0080_0008, 1'b1, "R9 valid low ignored");
    checks++;
    if (msg_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 msg_ready: actual %b expected 1", msg_ready);
    end

    reg_write(8'h20, 32'h0000_F000);
    send_msg(BASE, 32'h0000_6501);
    expect_reg(8'h00, 32'h0080_0008, 1'b1, "R3 disabled receiver ignores write");

    reg_write(8'h10, 32'hFFFF_FFFF);
    expect_reg(8'h14, 32'hFFFF_FFFF, 1'b0, "R6 mask all, R7 irq low");

    reg_write(8'h20, 32'h0000_F001);
    reg_write(8'h14, 32'h0000_0002);
    send_msg(BASE, 32'h0000_6501);
    expect_reg(8'h00, 32'h0080_000A, 1'b1, "R2 re-enabled vector 1");

    reg_write(8'h08, 32'hFFFF_FFFF);
    expect_reg(8'h00, 32'h0000_0000, 1'b0, "R5 clear all");

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule